// File: doc/BRIEF.md
# Banked Digital Port Register File

This block is a bank of up to twelve 8-bit digital ports behind a byte-wide memory-mapped bus. The bus has a write strobe, a read strobe, an 8-bit address and 8-bit write data. Read data comes back from a register one cycle after the strobe. Each port is fixed at build time as one of four kinds: input only, output only, bidirectional, or absent. A build-time option complements every output bit before it reaches the pins, which suits open-collector pad drivers.

Each present port has two registers at an address page of its own. The page holds an output latch, which is written through the data location. It also holds a direction bit, which can be changed only on bidirectional ports. A data read returns whatever the pins of that port show. For a port that is receiving, this is the pin level after a two-stage synchroniser. For a port that is driving, it is the byte the block is driving. A fixed identification byte sits at address zero. The other offsets of each port page belong to neighbouring filter and edge-detection blocks, so this block reads them as zero.

Top module: `dport_bank`

## Requirements
- R1: Port p (0 ≤ p < NUM_PORTS) has its data location at address 0x40 + 0x10·p and its direction location at 0x41 + 0x10·p. The address high nibble minus 4 is the port index. The low nibble selects the register: 0 for data, 1 for direction.
- R2: On synchronous reset (`rst` high) every output latch clears to 0x00. Bidirectional and input-only ports come up as inputs, with direction read 0x01 and `pin_oe` 0x00. Output-only ports come up driving, with `pin_oe` 0xFF.
- R3: A data write to an output-only or bidirectional port loads the latch. The new byte is on `pin_out` after the write edge. A bidirectional port that is currently an input still loads the latch and drives it once it is turned to output.
- R4: On a bidirectional port, a direction write takes bit 0 of the data as the new direction (1 = input, 0 = output) and ignores bits 7:1. `pin_oe` for that port is 0xFF when it is an output and 0x00 when it is an input. A direction read returns 0x01 for input and 0x00 for output.
- R5: Data writes to an input-only port have no effect. Direction writes to input-only or output-only ports have no effect.
- R6: A data read of a port that is an input returns its `pin_in` byte through a two-flop synchroniser. A data read of a port that is an output returns its `pin_out` byte.
- R7: With INVERT_OUT = 1, `pin_out` carries the bitwise complement of the latch, so a cleared latch drives 0xFF. A data read of an output port returns that complemented byte.
- R8: A read of address 0x00 returns the ID_VALUE parameter.
- R9: Absent ports drive `pin_out` and `pin_oe` to zero. Reads of their locations, of port pages beyond NUM_PORTS, of offsets other than 0 and 1 within a page, and of addresses 0x01 to 0x3F return 0x00. Writes there change nothing.
- R10: `rdata` changes only in the cycle after `rd_en` is high, and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 8·NUM_PORTS | Pin levels seen at the pads, port p in bits 8p+7:8p |
| pin_out | output | 8·NUM_PORTS | Levels to drive, port p in bits 8p+7:8p |
| pin_oe | output | 8·NUM_PORTS | Output enables, port p in bits 8p+7:8p |

## Verification
The bench targets the places where the port kind gates an access. Data writes to an input-only port are probed through `pin_oe` and `pin_out`. Direction writes to fixed ports are probed through the direction read and the enables; a design that let them through would start driving an input pad. The bidirectional port is loaded while it is still an input, then turned around. A design that dropped the early write, or that read the pins on a driving port, returns the wrong byte. Absent pages, stray offsets and the low address range are read and written. A decoder that ignored the page limit or the offset would alias the neighbouring registers. A second instance with inversion checks that a cleared latch drives all ones and that a readback shows the complemented byte. A design that inverted only on the read path, or only on the pins, fails there.

// File: rtl/dport_pkg.sv
package dport_pkg;

    localparam int LANE_W      = 8;
    localparam int MAX_PORTS   = 12;
    localparam logic [3:0] PAGE_BASE  = 4'h4;
    localparam logic [3:0] OFS_DATA   = 4'h0;
    localparam logic [3:0] OFS_DIR    = 4'h1;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'b00,
        KIND_IN    = 2'b01,
        KIND_OUT   = 2'b10,
        KIND_BIDIR = 2'b11
    } port_kind_e;

    typedef struct packed {
        logic [LANE_W-1:0] latch;
        logic              is_in;
    } lane_state_t;

    typedef struct packed {
        logic [LANE_W-1:0] rdata;
    } read_state_t;

endpackage

// File: rtl/dport_sync.sv
module dport_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q, meta_d;
    logic [W-1:0] stab_q, stab_d;

    always_comb begin
        meta_d = d_i;
        stab_d = meta_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/dport_decode.sv
module dport_decode #(
    parameter int NUM_PORTS = 12
) (
    input  logic [7:0] addr,
    output logic       hit_id,
    output logic       hit_data,
    output logic       hit_dir,
    output logic [3:0] port_idx
);
    import dport_pkg::*;

    logic [3:0] page;
    logic       in_bank;

    always_comb begin
        page     = addr[7:4];
        port_idx = page - PAGE_BASE;
        in_bank  = (page >= PAGE_BASE) && (int'(port_idx) < NUM_PORTS);
        hit_id   = (addr == 8'h00);
        hit_data = in_bank && (addr[3:0] == OFS_DATA);
        hit_dir  = in_bank && (addr[3:0] == OFS_DIR);
    end
endmodule

// File: rtl/dport_lane.sv
module dport_lane #(
    parameter dport_pkg::port_kind_e KIND   = dport_pkg::KIND_BIDIR,
    parameter bit                    INVERT = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_data,
    input  logic       wr_dir,
    input  logic [7:0] wdata,
    output logic [7:0] drive_o,
    output logic [7:0] oe_o,
    output logic       is_in_o
);
    import dport_pkg::*;

    localparam bit CAN_LOAD  = (KIND == KIND_OUT) || (KIND == KIND_BIDIR);
    localparam bit CAN_TURN  = (KIND == KIND_BIDIR);
    localparam bit RESET_IN  = (KIND != KIND_OUT);
    localparam bit PRESENT   = (KIND != KIND_NONE);

    lane_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_data && CAN_LOAD) st_d.latch = wdata;
        if (wr_dir && CAN_TURN)  st_d.is_in = wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.latch <= '0;
            st_q.is_in <= RESET_IN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        is_in_o = st_q.is_in;
        if (!PRESENT)    drive_o = '0;
        else if (INVERT) drive_o = ~st_q.latch;
        else             drive_o = st_q.latch;
        oe_o = (PRESENT && !st_q.is_in) ? 8'hFF : 8'h00;
    end

    generate
        if (CAN_LOAD) begin : g_load_chk
            assert_latch_load_R3: assert property (@(posedge clk) disable iff (rst)
                wr_data |=> st_q.latch == $past(wdata));
        end else begin : g_noload_chk
            assert_in_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
                wr_data |=> $stable(drive_o) && $stable(oe_o));
        end
        if (CAN_TURN) begin : g_turn_chk
            assert_dir_bit0_R4: assert property (@(posedge clk) disable iff (rst)
                wr_dir |=> st_q.is_in == $past(wdata[0]));
        end else begin : g_fixed_chk
            assert_dir_fixed_R5: assert property (@(posedge clk) disable iff (rst)
                $stable(is_in_o) && $stable(oe_o));
        end
    endgenerate
endmodule

// File: rtl/dport_bank.sv
module dport_bank #(
    parameter int          NUM_PORTS  = 12,
    parameter logic [23:0] PORT_KINDS = 24'h0FFA95,
    parameter bit          INVERT_OUT = 1'b0,
    parameter logic [7:0]  ID_VALUE   = 8'hA5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [7:0]             addr,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    input  logic [8*NUM_PORTS-1:0] pin_in,
    output logic [8*NUM_PORTS-1:0] pin_out,
    output logic [8*NUM_PORTS-1:0] pin_oe
);
    import dport_pkg::*;

    localparam int BUS_W = LANE_W * NUM_PORTS;

    logic       hit_id, hit_data, hit_dir;
    logic [3:0] port_idx;
    logic [BUS_W-1:0] pin_sync;

    logic [7:0] drive_a [NUM_PORTS];
    logic [7:0] sync_a  [NUM_PORTS];
    logic       is_in_a [NUM_PORTS];
    logic       here_a  [NUM_PORTS];

    dport_decode #(.NUM_PORTS(NUM_PORTS)) u_dec (
        .addr    (addr),
        .hit_id  (hit_id),
        .hit_data(hit_data),
        .hit_dir (hit_dir),
        .port_idx(port_idx)
    );

    dport_sync #(.W(BUS_W)) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i(pin_in),
        .q_o(pin_sync)
    );

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
            localparam port_kind_e KIND = port_kind_e'(PORT_KINDS[2*p +: 2]);
            logic sel;
            assign sel       = (int'(port_idx) == p);
            assign here_a[p] = (KIND != KIND_NONE);
            assign sync_a[p] = pin_sync[8*p +: 8];

            dport_lane #(.KIND(KIND), .INVERT(INVERT_OUT)) u_lane (
                .clk    (clk),
                .rst    (rst),
                .wr_data(wr_en && hit_data && sel),
                .wr_dir (wr_en && hit_dir && sel),
                .wdata  (wdata),
                .drive_o(drive_a[p]),
                .oe_o   (pin_oe[8*p +: 8]),
                .is_in_o(is_in_a[p])
            );
            assign pin_out[8*p +: 8] = drive_a[p];
        end
    endgenerate

    read_state_t rd_q, rd_d;

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d.rdata = 8'h00;
            if (hit_id) begin
                rd_d.rdata = ID_VALUE;
            end else if ((hit_data || hit_dir) && here_a[port_idx]) begin
                if (hit_dir)
                    rd_d.rdata = {7'b0, is_in_a[port_idx]};
                else if (is_in_a[port_idx])
                    rd_d.rdata = sync_a[port_idx];
                else
                    rd_d.rdata = drive_a[port_idx];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= '0;
        else     rd_q <= rd_d;
    end

    assign rdata = rd_q.rdata;

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
    assert_id_read_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 8'h00) |=> rdata == ID_VALUE);
    assert_low_range_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr != 8'h00 && addr < 8'h40) |=> rdata == 8'h00);
endmodule

// File: tb/sim_dport_bank.sv
module sim_dport_bank;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic        wr_en = 0, rd_en = 0;
    logic [7:0]  addr = 0, wdata = 0, rdata;
    logic [95:0] pin_in = '0, pin_out, pin_oe;

    logic        wr1 = 0, rd1 = 0;
    logic [7:0]  addr1 = 0, wdata1 = 0, rdata1;
    logic [15:0] pin_in1 = '0, pin_out1, pin_oe1;

    dport_bank u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    dport_bank #(.NUM_PORTS(2), .PORT_KINDS(24'h00000B), .INVERT_OUT(1'b1), .ID_VALUE(8'h3C)) u1 (
        .clk(clk), .rst(rst), .wr_en(wr1), .rd_en(rd1), .addr(addr1),
        .wdata(wdata1), .rdata(rdata1), .pin_in(pin_in1), .pin_out(pin_out1), .pin_oe(pin_oe1)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; d = rdata;
    endtask

    task automatic wr1_t(logic [7:0] a, logic [7:0] d);
        @(negedge clk); wr1 = 1; addr1 = a; wdata1 = d;
        @(negedge clk); wr1 = 0;
    endtask

    task automatic rd1_t(logic [7:0] a, output logic [7:0] d);
        @(negedge clk); rd1 = 1; addr1 = a;
        @(negedge clk); rd1 = 0; d = rdata1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(8'h51, v); chk("R2 input port dir", v, 8'h01);
        rd(8'h71, v); chk("R2 output port dir", v, 8'h00);
        rd(8'hA1, v); chk("R2 bidir port dir", v, 8'h01);
        chk("R2 input oe", pin_oe[15:8], 8'h00);
        chk("R2 output oe", pin_oe[39:32], 8'hFF);
        chk("R2 bidir oe", pin_oe[55:48], 8'h00);
        chk("R2 output latch", pin_out[31:24], 8'h00);
    endtask

    task automatic t_id();
        logic [7:0] v;
        rd(8'h00, v); chk("R8 id byte", v, 8'hA5);
    endtask

    task automatic t_output();
        logic [7:0] v;
        wr(8'h70, 8'h3C);
        chk("R3 R1 port3 pins", pin_out[31:24], 8'h3C);
        chk("R1 port4 untouched", pin_out[39:32], 8'h00);
        rd(8'h70, v); chk("R6 output readback", v, 8'h3C);
        wr(8'h90, 8'hC3);
        chk("R3 port5 pins", pin_out[47:40], 8'hC3);
    endtask

    task automatic t_input();
        logic [7:0] v;
        @(negedge clk); pin_in[15:8] = 8'h96;
        repeat (3) @(negedge clk);
        rd(8'h50, v); chk("R6 synced pins port1", v, 8'h96);
        wr(8'h50, 8'hFF);
        chk("R5 input data write oe", pin_oe[15:8], 8'h00);
        chk("R5 input data write out", pin_out[15:8], 8'h00);
        wr(8'h51, 8'h00);
        rd(8'h51, v); chk("R5 input dir write", v, 8'h01);
        chk("R5 input dir oe", pin_oe[15:8], 8'h00);
        wr(8'h71, 8'h01);
        rd(8'h71, v); chk("R5 output dir write", v, 8'h00);
        chk("R5 output dir oe", pin_oe[31:24], 8'hFF);
    endtask

    task automatic t_bidir();
        logic [7:0] v;
        @(negedge clk); pin_in[55:48] = 8'h11;
        wr(8'hA0, 8'h5A);
        chk("R4 bidir still input oe", pin_oe[55:48], 8'h00);
        repeat (2) @(negedge clk);
        rd(8'hA0, v); chk("R6 bidir input reads pins", v, 8'h11);
        wr(8'hA1, 8'hFE);
        chk("R4 bidir turned oe", pin_oe[55:48], 8'hFF);
        chk("R3 early load drives", pin_out[55:48], 8'h5A);
        rd(8'hA1, v); chk("R4 dir reads output", v, 8'h00);
        rd(8'hA0, v); chk("R6 bidir output readback", v, 8'h5A);
        wr(8'hA1, 8'h01);
        chk("R4 bidir back to input", pin_oe[55:48], 8'h00);
    endtask

    task automatic t_unused();
        logic [7:0] v;
        @(negedge clk); pin_in[87:80] = 8'hFF;
        repeat (3) @(negedge clk);
        rd(8'hE0, v); chk("R9 absent port data", v, 8'h00);
        wr(8'hE0, 8'h77); wr(8'hE1, 8'h00);
        chk("R9 absent oe", pin_oe[87:80], 8'h00);
        chk("R9 absent out", pin_out[87:80], 8'h00);
        rd(8'h02, v); chk("R9 low range", v, 8'h00);
        rd(8'h72, v); chk("R9 stray offset", v, 8'h00);
        wr(8'h02, 8'h99);
        rd(8'h70, v); chk("R9 stray write no effect", v, 8'h3C);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        rd(8'h00, v);
        @(negedge clk); addr = 8'h70;
        repeat (3) @(negedge clk);
        chk("R10 rdata held", rdata, 8'hA5);
    endtask

    task automatic t_invert();
        logic [7:0] v;
        chk("R7 cleared latch drives ones", pin_out1[15:8], 8'hFF);
        chk("R7 output oe", pin_oe1[15:8], 8'hFF);
        wr1_t(8'h50, 8'h0F);
        chk("R7 inverted pins", pin_out1[15:8], 8'hF0);
        rd1_t(8'h50, v); chk("R7 inverted readback", v, 8'hF0);
        rd1_t(8'h60, v); chk("R9 page beyond NUM_PORTS", v, 8'h00);
        rd1_t(8'h00, v); chk("R8 id second instance", v, 8'h3C);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        t_reset();
        t_id();
        t_output();
        t_input();
        t_bidir();
        t_unused();
        t_hold();
        t_invert();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule